// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block works out which local interrupt units an interrupt request should reach. A request carries a destination byte, a physical/logical mode flag, a two-bit shorthand code, a three-bit delivery mode, level and trigger bits, and the index of the sending unit. The block turns these into a bitmask with one bit per unit. It reads a small programmable table that holds, for each unit, a presence flag, a physical ID, a logical-destination byte and a 4-bit format model.

Lowest-priority requests are reduced to one target, the lowest-indexed selected unit. An INIT de-assert request delivers nothing. Instead it raises a one-cycle resync pulse together with the set of units that were selected. Results appear a fixed two clock edges after the request strobe and are held until the next result.

Top module: `idr_resolver`

## Requirements
- R1: With shorthand 0 and physical mode (`req_logical`=0), destination 0xFF sets every bit of the mask, whether or not a unit is present.
- R2: With shorthand 0, physical mode and a destination other than 0xFF, only the lowest-indexed present unit whose physical ID equals the destination is selected. If no present unit matches, the mask is zero.
- R3: In logical mode, a unit with format model 4'hF is selected when the destination ANDed with its logical byte is nonzero.
- R4: In logical mode, a unit with format model 4'h0 is selected when the upper nibbles of the destination and its logical byte are equal and their lower nibbles share a set bit. A unit with any other format model is never selected in logical mode.
- R5: In logical mode, only units below the lowest-indexed absent table entry can be selected.
- R6: Shorthand 1 selects only the sender (`req_src`), shorthand 2 selects every unit, and shorthand 3 selects every unit except the sender. The destination fields are ignored for these codes.
- R7: For delivery mode 3'b001 (lowest priority), the result keeps only the lowest-indexed bit of the selection.
- R8: A request with delivery mode 3'b101, level 0 and trigger 1 gives an all-zero result mask and raises `sync_pulse` for one cycle, with `sync_mask` equal to the selection. Any other request gives `sync_pulse` low and `sync_mask` zero.
- R9: For a strobe sampled at edge k, `res_valid` is high for exactly the cycle after edge k+1, and the result outputs take their new values at edge k+1.
- R10: After reset all outputs are zero, and `res_mask` and `sync_mask` hold their values until the next result.
- R11: A table write takes effect for requests strobed in later cycles. A request strobed in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_present | input | 1 | Entry is populated |
| tbl_phys_id | input | 8 | Physical ID of the entry |
| tbl_log_dest | input | 8 | Logical-destination byte of the entry |
| tbl_fmt | input | 4 | Format model (4'hF flat, 4'h0 cluster) |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 1 = logical mode, 0 = physical |
| req_short | input | 2 | Shorthand code |
| req_mode | input | 3 | Delivery mode |
| req_level | input | 1 | Level bit |
| req_trig | input | 1 | Trigger bit |
| req_src | input | IDX_W | Index of the sending unit |
| res_valid | output | 1 | One-cycle result strobe |
| res_mask | output | N | Delivery bitmask |
| sync_pulse | output | 1 | Arbitration-ID resync pulse |
| sync_mask | output | N | Units to resync |

## Verification
Every result is due two clock edges after the edge that samples the strobe: one edge registers the selection and one registers the reduced result. The bench drives at falling edges. Each targeted case checks that `res_valid` is still low after the first rising edge and is high, with the hand-computed mask, after the second. A behavioural model in the bench tracks the same two-edge delay and is compared with all four outputs at every falling edge, which also covers the hold behaviour between results. Because the model updates its table non-blockingly, it matches the rule that a same-cycle write is not yet visible.

// File: rtl/idr_pkg.sv
package idr_pkg;
   typedef enum logic [2:0] {
      DM_FIXED  = 3'b000,
      DM_LOWEST = 3'b001,
      DM_SMI    = 3'b010,
      DM_NMI    = 3'b100,
      DM_INIT   = 3'b101,
      DM_START  = 3'b110,
      DM_EXT    = 3'b111
   } dmode_e;

   typedef enum logic [1:0] {
      SH_NONE    = 2'd0,
      SH_SELF    = 2'd1,
      SH_ALL     = 2'd2,
      SH_OTHERS  = 2'd3
   } short_e;

   localparam logic [3:0] FMT_FLAT    = 4'hF;
   localparam logic [3:0] FMT_CLUSTER = 4'h0;
   localparam logic [7:0] DEST_BCAST  = 8'hFF;
endpackage

// File: rtl/idr_pick.sv
module idr_pick #(
   parameter int N     = 8,
   parameter int STYLE = 0
) (
   input  logic [N-1:0] vec_in,
   output logic [N-1:0] vec_out
);
   generate
      if (STYLE == 0) begin : g_arith
         assign vec_out = vec_in & (~vec_in + N'(1));
      end else begin : g_chain
         logic [N:0] seen;
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign vec_out[i]  = vec_in[i] & ~seen[i];
            assign seen[i+1]   = seen[i] | vec_in[i];
         end
      end
   endgenerate
endmodule

// File: rtl/idr_table.sv
module idr_table #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    idx,
   input  logic                present_in,
   input  logic [7:0]          phys_in,
   input  logic [7:0]          log_in,
   input  logic [3:0]          fmt_in,
   output logic [N-1:0]        present,
   output logic [N-1:0][7:0]   phys_id,
   output logic [N-1:0][7:0]   log_dest,
   output logic [N-1:0][3:0]   fmt
);
   for (genvar i = 0; i < N; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            present[i]  <= 1'b0;
            phys_id[i]  <= '0;
            log_dest[i] <= '0;
            fmt[i]      <= '0;
         end else if (we && idx == IDX_W'(i)) begin
            present[i]  <= present_in;
            phys_id[i]  <= phys_in;
            log_dest[i] <= log_in;
            fmt[i]      <= fmt_in;
         end
      end
   end
endmodule

// File: rtl/idr_match.sv
module idr_match
   import idr_pkg::*;
#(
   parameter int N          = 8,
   parameter int IDX_W      = $clog2(N),
   parameter int PICK_STYLE = 0
) (
   input  logic [N-1:0]        present,
   input  logic [N-1:0][7:0]   phys_id,
   input  logic [N-1:0][7:0]   log_dest,
   input  logic [N-1:0][3:0]   fmt,
   input  logic [7:0]          dest,
   input  logic                logical,
   input  logic [1:0]          short,
   input  logic [IDX_W-1:0]    src,
   output logic [N-1:0]        sel
);
   logic [N-1:0] phys_hit, phys_one, log_hit, alive, src_oh;

   for (genvar i = 0; i < N; i++) begin : g_unit
      logic flat_ok, clus_ok;
      assign phys_hit[i] = present[i] && (phys_id[i] == dest);
      assign flat_ok     = (fmt[i] == FMT_FLAT) && ((dest & log_dest[i]) != 8'h00);
      assign clus_ok     = (fmt[i] == FMT_CLUSTER)
                        && (dest[7:4] == log_dest[i][7:4])
                        && ((dest[3:0] & log_dest[i][3:0]) != 4'h0);
      if (i == 0) begin : g_first
         assign alive[i] = present[i];
      end else begin : g_rest
         assign alive[i] = alive[i-1] & present[i];
      end
      assign log_hit[i] = alive[i] & (flat_ok | clus_ok);
      assign src_oh[i]  = (src == IDX_W'(i));
   end

   idr_pick #(.N(N), .STYLE(PICK_STYLE)) u_phys_pick (
      .vec_in  (phys_hit),
      .vec_out (phys_one)
   );

   always_comb begin
      unique case (short_e'(short))
         SH_SELF:   sel = src_oh;
         SH_ALL:    sel = '1;
         SH_OTHERS: sel = ~src_oh;
         default: begin
            if (logical)                  sel = log_hit;
            else if (dest == DEST_BCAST)  sel = '1;
            else                          sel = phys_one;
         end
      endcase
   end
endmodule

// File: rtl/idr_resolver.sv
module idr_resolver
   import idr_pkg::*;
#(
   parameter int N          = 8,
   parameter int IDX_W      = $clog2(N),
   parameter int PICK_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic              tbl_present,
   input  logic [7:0]        tbl_phys_id,
   input  logic [7:0]        tbl_log_dest,
   input  logic [3:0]        tbl_fmt,
   input  logic              req_valid,
   input  logic [7:0]        req_dest,
   input  logic              req_logical,
   input  logic [1:0]        req_short,
   input  logic [2:0]        req_mode,
   input  logic              req_level,
   input  logic              req_trig,
   input  logic [IDX_W-1:0]  req_src,
   output logic              res_valid,
   output logic [N-1:0]      res_mask,
   output logic              sync_pulse,
   output logic [N-1:0]      sync_mask
);
   if (N < 2 || N > 256) begin : g_bad_n
      $error("idr_resolver: N must be in 2..256");
   end
   if (IDX_W < $clog2(N)) begin : g_bad_w
      $error("idr_resolver: IDX_W too narrow for N");
   end
   if (PICK_STYLE != 0 && PICK_STYLE != 1) begin : g_bad_pick
      $error("idr_resolver: PICK_STYLE must be 0 or 1");
   end

   logic [N-1:0]        t_present;
   logic [N-1:0][7:0]   t_phys, t_log;
   logic [N-1:0][3:0]   t_fmt;
   logic [N-1:0]        sel_now, low_one;
   logic [N-1:0]        s1_sel;
   logic                s1_v, s1_low, s1_init;
   logic                init_deassert;

   idr_table #(.N(N), .IDX_W(IDX_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (tbl_we),
      .idx        (tbl_idx),
      .present_in (tbl_present),
      .phys_in    (tbl_phys_id),
      .log_in     (tbl_log_dest),
      .fmt_in     (tbl_fmt),
      .present    (t_present),
      .phys_id    (t_phys),
      .log_dest   (t_log),
      .fmt        (t_fmt)
   );

   idr_match #(.N(N), .IDX_W(IDX_W), .PICK_STYLE(PICK_STYLE)) u_match (
      .present  (t_present),
      .phys_id  (t_phys),
      .log_dest (t_log),
      .fmt      (t_fmt),
      .dest     (req_dest),
      .logical  (req_logical),
      .short    (req_short),
      .src      (req_src),
      .sel      (sel_now)
   );

   assign init_deassert = (dmode_e'(req_mode) == DM_INIT) && !req_level && req_trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_sel  <= '0;
         s1_low  <= 1'b0;
         s1_init <= 1'b0;
      end else begin
         s1_v <= req_valid;
         if (req_valid) begin
            s1_sel  <= sel_now;
            s1_low  <= (dmode_e'(req_mode) == DM_LOWEST);
            s1_init <= init_deassert;
         end
      end
   end

   idr_pick #(.N(N), .STYLE(PICK_STYLE)) u_low_pick (
      .vec_in  (s1_sel),
      .vec_out (low_one)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_mask   <= '0;
         sync_pulse <= 1'b0;
         sync_mask  <= '0;
      end else begin
         res_valid  <= s1_v;
         sync_pulse <= s1_v && s1_init;
         if (s1_v) begin
            res_mask  <= s1_init ? '0 : (s1_low ? low_one : s1_sel);
            sync_mask <= s1_init ? s1_sel : '0;
         end
      end
   end
endmodule

// File: rtl/idr_chk.sv
module idr_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic [2:0]   req_mode,
   input logic         res_valid,
   input logic [N-1:0] res_mask,
   input logic         sync_pulse,
   input logic [N-1:0] sync_mask
);
   // R9
   res_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == $past(req_valid, 2));

   // R10
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ($stable(res_mask) && $stable(sync_mask)));

   // R8
   sync_no_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> (res_valid && res_mask == '0));

   // R8
   sync_mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !sync_pulse) |-> (sync_mask == '0));

   // R7
   lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(req_mode, 2) == 3'b001) |-> $onehot0(res_mask));
endmodule

bind idr_resolver idr_chk #(.N(N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_mode   (req_mode),
   .res_valid  (res_valid),
   .res_mask   (res_mask),
   .sync_pulse (sync_pulse),
   .sync_mask  (sync_mask)
);

// File: tb/idr_resolver_tb_top.sv
`timescale 1ns/1ps
module idr_resolver_tb_top;
   localparam int N     = 8;
   localparam int IDX_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_we = 1'b0;
   logic [IDX_W-1:0] tbl_idx = '0;
   logic tbl_present = 1'b0;
   logic [7:0] tbl_phys_id = '0, tbl_log_dest = '0;
   logic [3:0] tbl_fmt = '0;
   logic req_valid = 1'b0;
   logic [7:0] req_dest = '0;
   logic req_logical = 1'b0;
   logic [1:0] req_short = '0;
   logic [2:0] req_mode = '0;
   logic req_level = 1'b0, req_trig = 1'b0;
   logic [IDX_W-1:0] req_src = '0;
   logic res_valid, sync_pulse;
   logic [N-1:0] res_mask, sync_mask;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   idr_resolver #(.N(N), .IDX_W(IDX_W)) dut_i (.*);

   // behavioural reference model
   bit         t_pres [N];
   logic [7:0] t_id   [N];
   logic [7:0] t_log  [N];
   logic [3:0] t_fmt  [N];
   logic         m1_v, m1_low, m1_init, m_valid, m_sp;
   logic [N-1:0] m1_sel, m_mask, m_sync;

   function automatic logic [N-1:0] ref_sel(logic [7:0] d, logic lg, logic [1:0] sh, int src);
      logic [N-1:0] r = '0;
      bit stop = 0, found = 0;
      if (sh == 2'd1) r[src] = 1'b1;
      else if (sh == 2'd2) r = '1;
      else if (sh == 2'd3) begin r = '1; r[src] = 1'b0; end
      else if (!lg) begin
         if (d == 8'hFF) r = '1;
         else for (int i = 0; i < N; i++)
            if (!found && t_pres[i] && t_id[i] == d) begin r[i] = 1'b1; found = 1; end
      end else begin
         for (int i = 0; i < N; i++) begin
            if (!t_pres[i]) stop = 1;
            if (!stop) begin
               if (t_fmt[i] == 4'hF && (d & t_log[i]) != 0) r[i] = 1'b1;
               if (t_fmt[i] == 4'h0 && d[7:4] == t_log[i][7:4] && (d[3:0] & t_log[i][3:0]) != 0)
                  r[i] = 1'b1;
            end
         end
      end
      return r;
   endfunction

   function automatic logic [N-1:0] lowest(logic [N-1:0] v);
      logic [N-1:0] r = '0;
      for (int i = N - 1; i >= 0; i--) if (v[i]) r = (N'(1) << i);
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_v <= 0; m1_low <= 0; m1_init <= 0; m1_sel <= '0;
         m_valid <= 0; m_sp <= 0; m_mask <= '0; m_sync <= '0;
         for (int i = 0; i < N; i++) begin t_pres[i] <= 0; t_id[i] <= 0; t_log[i] <= 0; t_fmt[i] <= 0; end
      end else begin
         m1_v <= req_valid;
         if (req_valid) begin
            m1_sel  <= ref_sel(req_dest, req_logical, req_short, int'(req_src));
            m1_low  <= (req_mode == 3'b001);
            m1_init <= (req_mode == 3'b101) && !req_level && req_trig;
         end
         m_valid <= m1_v;
         m_sp    <= m1_v && m1_init;
         if (m1_v) begin
            m_mask <= m1_init ? '0 : (m1_low ? lowest(m1_sel) : m1_sel);
            m_sync <= m1_init ? m1_sel : '0;
         end
         if (tbl_we) begin
            t_pres[tbl_idx] <= tbl_present; t_id[tbl_idx] <= tbl_phys_id;
            t_log[tbl_idx] <= tbl_log_dest; t_fmt[tbl_idx] <= tbl_fmt;
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model comparison on every clock (R9 timing, R10 hold)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R9 res_valid vs model", 32'(res_valid), 32'(m_valid));
         check("R10 res_mask vs model", 32'(res_mask), 32'(m_mask));
         check("R8 sync_pulse vs model", 32'(sync_pulse), 32'(m_sp));
         check("R8 sync_mask vs model", 32'(sync_mask), 32'(m_sync));
      end
   end

   task automatic twrite(int idx, bit pres, logic [7:0] id, logic [7:0] lg, logic [3:0] f);
      @(negedge clk);
      tbl_we = 1; tbl_idx = IDX_W'(idx); tbl_present = pres;
      tbl_phys_id = id; tbl_log_dest = lg; tbl_fmt = f;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic issue(string tag, logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] dm,
                        logic lv, logic tr, int src, logic [N-1:0] exp_res,
                        logic exp_sp, logic [N-1:0] exp_sync);
      @(negedge clk);
      req_valid = 1; req_dest = d; req_logical = lg; req_short = sh;
      req_mode = dm; req_level = lv; req_trig = tr; req_src = IDX_W'(src);
      @(negedge clk);
      req_valid = 0;
      check({tag, " R9 not yet valid"}, 32'(res_valid), 32'd0);
      @(negedge clk);
      check({tag, " R9 valid"}, 32'(res_valid), 32'd1);
      check({tag, " mask"}, 32'(res_mask), 32'(exp_res));
      check({tag, " sync_pulse"}, 32'(sync_pulse), 32'(exp_sp));
      check({tag, " sync_mask"}, 32'(sync_mask), 32'(exp_sync));
      @(negedge clk);
      check({tag, " R9 single cycle"}, 32'(res_valid), 32'd0);
   endtask

   initial begin
      #(4.0 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset res_valid", 32'(res_valid), 0);
      check("R10 reset res_mask", 32'(res_mask), 0);
      check("R10 reset sync", 32'({sync_pulse, sync_mask}), 0);
      rst_n = 1;

      twrite(0, 1, 8'h10, 8'h01, 4'hF);
      twrite(1, 1, 8'h11, 8'h02, 4'hF);
      twrite(2, 1, 8'h12, 8'h21, 4'h0);
      twrite(3, 1, 8'h12, 8'h23, 4'h0);
      twrite(4, 1, 8'h14, 8'h84, 4'h3);
      twrite(5, 1, 8'h15, 8'h06, 4'hF);
      twrite(6, 0, 8'h16, 8'hFF, 4'hF);
      twrite(7, 1, 8'h17, 8'hFF, 4'hF);

      issue("R1 broadcast",        8'hFF, 0, 0, 3'b000, 0, 0, 0, 8'hFF, 0, 8'h00);
      issue("R2 dup id lowest",    8'h12, 0, 0, 3'b000, 0, 0, 0, 8'h04, 0, 8'h00);
      issue("R2 id past gap",      8'h17, 0, 0, 3'b000, 0, 0, 0, 8'h80, 0, 8'h00);
      issue("R2 no match",         8'h33, 0, 0, 3'b000, 0, 0, 0, 8'h00, 0, 8'h00);
      issue("R3 flat",             8'h06, 1, 0, 3'b000, 0, 0, 0, 8'h22, 0, 8'h00);
      issue("R4 cluster",          8'h21, 1, 0, 3'b000, 0, 0, 0, 8'h0D, 0, 8'h00);
      issue("R4 other fmt",        8'h24, 1, 0, 3'b000, 0, 0, 0, 8'h20, 0, 8'h00);
      issue("R5 scan stop",        8'hFF, 1, 0, 3'b000, 0, 0, 0, 8'h23, 0, 8'h00);
      issue("R6 self",             8'h12, 0, 1, 3'b000, 0, 0, 3, 8'h08, 0, 8'h00);
      issue("R6 all",              8'h33, 1, 2, 3'b000, 0, 0, 3, 8'hFF, 0, 8'h00);
      issue("R6 others",           8'hFF, 0, 3, 3'b000, 0, 0, 3, 8'hF7, 0, 8'h00);
      issue("R7 lowest logical",   8'h06, 1, 0, 3'b001, 0, 0, 0, 8'h02, 0, 8'h00);
      issue("R7 lowest others",    8'h00, 0, 3, 3'b001, 0, 0, 0, 8'h02, 0, 8'h00);
      issue("R8 init deassert",    8'h00, 0, 2, 3'b101, 0, 1, 0, 8'h00, 1, 8'hFF);
      issue("R8 init assert",      8'h00, 0, 2, 3'b101, 1, 1, 0, 8'hFF, 0, 8'h00);

      // R10 hold across idle cycles
      repeat (4) @(negedge clk);
      check("R10 hold res_mask", 32'(res_mask), 32'h000000FF);
      check("R10 hold res_valid", 32'(res_valid), 0);

      // R11 write then request
      twrite(4, 1, 8'h14, 8'h84, 4'hF);
      issue("R11 after write",     8'h24, 1, 0, 3'b000, 0, 0, 0, 8'h30, 0, 8'h00);
      // R11 same-cycle write sees old entry
      @(negedge clk);
      tbl_we = 1; tbl_idx = 3'd1; tbl_present = 1; tbl_phys_id = 8'h11;
      tbl_log_dest = 8'h80; tbl_fmt = 4'hF;
      req_valid = 1; req_dest = 8'h80; req_logical = 1; req_short = 0;
      req_mode = 3'b000; req_level = 0; req_trig = 0;
      @(negedge clk);
      tbl_we = 0; req_valid = 0;
      @(negedge clk);
      check("R11 same cycle old entry", 32'(res_mask), 32'h10);
      issue("R11 next request",    8'h80, 1, 0, 3'b000, 0, 0, 0, 8'h12, 0, 8'h00);

      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule